// File: doc/BRIEF.md
# Single-Path Greedy Trellis Decoder

This block decodes a hard-decision stream of 2-bit code symbols produced by a rate-1/2 convolutional encoder with constraint length 3 and generator polynomials 7 and 5 (octal). The trellis has four states. Instead of keeping a survivor path for every state, the block keeps one current state. For each received symbol it computes the Hamming distance to the two branches leaving that state and moves along the nearer branch. The input bit of that branch is the decoded bit.

A frame-start pulse puts the walk back at state zero and clears the accumulated path metric. The path metric is the sum of the Hamming distances of the branches taken, and it gives a rough measure of channel quality for the frame. The two branches leaving any state carry complementary symbols, so the two distances always sum to two. A tie therefore means a distance of one on each branch. A tie is settled by a pseudo-random bit, so a single channel error can be decoded wrongly. Each symbol costs two metric additions and one comparison, so a 7-symbol frame needs 14 additions and 7 comparisons.

Top module: `greedy_trellis_decoder`

## Requirements
- R1: While reset is held low and just after its release, bit_valid_o is 0, bit_o is 0 and metric_o is 0.
- R2: The trellis state is {s1,s0}. From that state, input bit u produces the code symbol {u^s1^s0, u^s0}, where the left bit is sym_i[1], and leads to the next state {u,s1}. With this encoding the message 101100 from state 0 gives 11 10 00 01 01 11.
- R3: For each accepted symbol the block takes the branch whose symbol is nearer in Hamming distance to sym_i, and bit_o becomes that branch's input bit. An error-free encoded frame therefore decodes to its message.
- R4: metric_o adds the Hamming distance of the chosen branch, which is 0 or 1, for every accepted symbol.
- R5: metric_o saturates at its maximum value of 15 and stays there until the next frame start.
- R6: bit_valid_o is high for exactly the one clock that follows each cycle with sym_valid_i high, and low otherwise. While no symbol is accepted, bit_o and metric_o hold their values.
- R7: When frame_start_i is high together with sym_valid_i, that symbol is decoded from state 0 and adds to a metric of 0.
- R8: On a tie the chosen input bit is bit 0 of a 4-bit LFSR. The LFSR is loaded with the seed parameter (default 4'b1001) at reset and steps q <= {q[2:0], q[3]^q[2]} only when a tie is resolved.
- R9: frame_start_i without sym_valid_i clears metric_o to 0 and returns the state to 0. It produces no bit_valid_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Restart the walk at state 0 and clear the metric |
| sym_valid_i | input | 1 | sym_i carries a symbol this cycle |
| sym_i | input | 2 | Received hard-decision code symbol |
| bit_valid_o | output | 1 | One-clock strobe marking a decoded bit |
| bit_o | output | 1 | Decoded bit |
| metric_o | output | 4 | Saturating accumulated path metric |

## Verification
The assertions assume that sym_i is stable and defined in every cycle where sym_valid_i is high, and that frame_start_i is a clean single-cycle pulse. They also assume that the metric grows by at most one per symbol, which holds only because the two branch symbols are complementary. The bench drives all inputs on the falling clock edge and holds sym_i steady across the whole cycle. Idle cycles keep sym_valid_i low, and the bench places frame starts either alone or on the first symbol of a frame. For the saturation run, the bench tracks the decoder state from the decoded bits. It then picks each symbol so that it is a forced tie.

// File: rtl/gtd_pkg.sv
package gtd_pkg;
  typedef logic [1:0] trellis_state_t;
  typedef logic [1:0] code_sym_t;

  function automatic code_sym_t branch_symbol(logic u, trellis_state_t st);
    return {u ^ st[1] ^ st[0], u ^ st[0]};
  endfunction

  function automatic trellis_state_t branch_next(logic u, trellis_state_t st);
    return {u, st[1]};
  endfunction
endpackage

// File: rtl/gtd_branch_metric.sv
module gtd_branch_metric
  import gtd_pkg::*;
(
  input  trellis_state_t st_i,
  input  code_sym_t      sym_i,
  output logic [1:0]     bm0_o,
  output logic [1:0]     bm1_o
);
  logic [1:0] bm [2];

  for (genvar u = 0; u < 2; u++) begin : g_branch
    code_sym_t diff;
    always_comb begin
      diff  = sym_i ^ branch_symbol(u[0], st_i);
      bm[u] = {1'b0, diff[1]} + {1'b0, diff[0]};
    end
  end

  assign bm0_o = bm[0];
  assign bm1_o = bm[1];
endmodule

// File: rtl/gtd_tie_lfsr.sv
module gtd_tie_lfsr #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] SEED = 4'b1001,
  parameter logic [W-1:0] TAPS = 4'b1100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  output logic bit_o
);
  logic [W-1:0] q, q_d;

  always_comb begin
    q_d = q;
    if (step_i) q_d = {q[W-2:0], ^(q & TAPS)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= SEED;
    else        q <= q_d;
  end

  assign bit_o = q[0];

  assert_lfsr_alive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    q != '0);
endmodule

// File: rtl/gtd_metric_acc.sv
module gtd_metric_acc #(
  parameter int unsigned MW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          add_en_i,
  input  logic [1:0]    inc_i,
  output logic [MW-1:0] metric_o
);
  localparam logic [MW-1:0] MAX_M = {MW{1'b1}};

  logic [MW-1:0] q, q_d, base;
  logic [MW:0]   sum;

  always_comb begin
    base = clear_i ? '0 : q;
    sum  = {1'b0, base} + {{(MW-1){1'b0}}, inc_i};
    q_d  = base;
    if (add_en_i) q_d = (sum > {1'b0, MAX_M}) ? MAX_M : sum[MW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

  assign metric_o = q;

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (add_en_i && !clear_i && q == MAX_M) |=> (q == MAX_M));
  assert_unit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (add_en_i && !clear_i && q != MAX_M) |=> (q >= $past(q) && q <= $past(q) + 1'b1));
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && !add_en_i) |=> (q == '0));
endmodule

// File: rtl/greedy_trellis_decoder.sv
module greedy_trellis_decoder
  import gtd_pkg::*;
#(
  parameter int unsigned MW = 4,
  parameter int unsigned LFSR_W = 4,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 4'b1001,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 4'b1100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start_i,
  input  logic          sym_valid_i,
  input  logic [1:0]    sym_i,
  output logic          bit_valid_o,
  output logic          bit_o,
  output logic [MW-1:0] metric_o
);
  trellis_state_t state_q, state_d, base_state;
  logic [1:0] bm0, bm1, bm_pick, bm_other;
  logic tie, tie_bit, pick_u;
  logic valid_q, bit_q, bit_d;

  assign base_state = frame_start_i ? '0 : state_q;

  gtd_branch_metric u_bm (
    .st_i  (base_state),
    .sym_i (sym_i),
    .bm0_o (bm0),
    .bm1_o (bm1)
  );

  assign tie = (bm0 == bm1);

  gtd_tie_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED), .TAPS(LFSR_TAPS)) u_lfsr (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_i (sym_valid_i & tie),
    .bit_o  (tie_bit)
  );

  always_comb begin
    pick_u   = tie ? tie_bit : (bm1 < bm0);
    bm_pick  = pick_u ? bm1 : bm0;
    bm_other = pick_u ? bm0 : bm1;
    state_d  = base_state;
    bit_d    = bit_q;
    if (sym_valid_i) begin
      state_d = branch_next(pick_u, base_state);
      bit_d   = pick_u;
    end
  end

  gtd_metric_acc #(.MW(MW)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (frame_start_i),
    .add_en_i (sym_valid_i),
    .inc_i    (bm_pick),
    .metric_o (metric_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      valid_q <= 1'b0;
      bit_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= sym_valid_i;
      bit_q   <= bit_d;
    end
  end

  assign bit_valid_o = valid_q;
  assign bit_o       = bit_q;

  assert_nearest_branch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid_i |-> (bm_pick <= bm_other));
  assert_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid_i |=> bit_valid_o);
  assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sym_valid_i && !frame_start_i) |=> (!bit_valid_o && $stable(bit_o) && $stable(metric_o)));
  assert_branch_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid_i |-> ({1'b0, bm0} + {1'b0, bm1} == 3'd2));
endmodule

// File: tb/greedy_trellis_decoder_test.sv
module greedy_trellis_decoder_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int NV = 15;
  // {frame_start, sym[1:0], expected bit, expected metric[3:0]}
  localparam logic [7:0] VEC [NV] = '{
    8'b1_11_1_0000, 8'b0_10_0_0000, 8'b0_00_1_0000,
    8'b0_01_1_0000, 8'b0_01_0_0000, 8'b0_11_0_0000,
    8'b1_10_1_0001, 8'b0_10_0_0001, 8'b0_00_1_0001,
    8'b0_01_1_0001, 8'b0_01_0_0001, 8'b0_11_0_0001,
    8'b1_10_1_0001, 8'b0_01_1_0001, 8'b0_11_0_0010
  };

  logic clk = 1'b0;
  logic rst_n;
  logic frame_start_i, sym_valid_i;
  logic [1:0] sym_i;
  logic bit_valid_o, bit_o;
  logic [3:0] metric_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  greedy_trellis_decoder uut (
    .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start_i),
    .sym_valid_i(sym_valid_i), .sym_i(sym_i),
    .bit_valid_o(bit_valid_o), .bit_o(bit_o), .metric_o(metric_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input logic fs, input logic v, input logic [1:0] s);
    frame_start_i = fs;
    sym_valid_i   = v;
    sym_i         = s;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] lf;
    logic [1:0] st;
    int exp_m;
    rst_n = 1'b0; frame_start_i = 0; sym_valid_i = 0; sym_i = 0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", bit_valid_o, 0);
    chk("R1 bit in reset", bit_o, 0);
    chk("R1 metric in reset", metric_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", bit_valid_o, 0);
    chk("R1 metric after release", metric_o, 0);

    // R2 R3 R4 R7 R8: clean frame, tied first symbols resolved by LFSR
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][7], 1'b1, VEC[i][6:5]);
      chk($sformatf("R6 strobe vec %0d", i), bit_valid_o, 1);
      chk($sformatf("R3 R8 bit vec %0d", i), bit_o, VEC[i][4]);
      chk($sformatf("R4 R7 metric vec %0d", i), metric_o, VEC[i][3:0]);
    end

    // R6: idle cycles hold outputs
    apply(0, 0, 2'b11);
    chk("R6 idle valid", bit_valid_o, 0);
    apply(0, 0, 2'b01);
    chk("R6 idle bit hold", bit_o, 0);
    chk("R6 idle metric hold", metric_o, 2);

    // R9: lone frame start clears metric, no strobe, state back to 0
    apply(1, 0, 2'b00);
    chk("R9 no strobe", bit_valid_o, 0);
    chk("R9 metric cleared", metric_o, 0);
    apply(0, 1, 2'b11);
    chk("R9 decoded from state 0", bit_o, 1);
    chk("R9 metric after", metric_o, 0);

    // R1: mid-run reset
    apply(0, 1, 2'b10);
    rst_n = 1'b0;
    #1;
    chk("R1 async valid", bit_valid_o, 0);
    chk("R1 async metric", metric_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    sym_valid_i = 0;
    @(negedge clk);

    // R5 R8: forced ties until saturation, LFSR reseeded by reset
    lf = 4'b1001; st = 2'b00; exp_m = 0;
    for (int i = 0; i < 20; i++) begin
      logic eu;
      eu = lf[0];
      lf = {lf[2:0], lf[3] ^ lf[2]};
      apply(i == 0, 1'b1, st[1] ? 2'b00 : 2'b10);
      exp_m = (exp_m + 1 > 15) ? 15 : exp_m + 1;
      chk($sformatf("R8 tie bit %0d", i), bit_o, eu);
      chk($sformatf("R5 metric %0d", i), metric_o, exp_m);
      st = {eu, st[1]};
    end
    apply(0, 0, 2'b00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule